// File: doc/BRIEF.md
# Multiplexed Bus Cycle Sequencer

This block runs the external bus machine cycles for a small 8-bit processor core with a 16-bit address space. The low address byte and the data byte share one set of pins. The core side issues a request that carries a cycle kind, an address and write data. The block then steps through the T-states for that kind. It drives the high address byte, the shared low byte with its output enable, the address strobe, the active-low read and write strobes, and three status lines that identify the cycle. When the final T-state ends, it returns a one-state done pulse and, for reading cycles, the byte it captured.

The oscillator clock feeds an internal divider, and the T-state rate is half the oscillator rate. Every register in the block runs on the oscillator clock and advances only on the divider's enable. The divided phase is also brought out so that the rest of a system can follow the state rate.

Top module: `bus_cycle_seq`

## Requirements
- R1: One T-state lasts exactly two `clk` cycles. `state_clk` is low for the first `clk` cycle of each T-state and high for the second.
- R2: In T1 only, `ale` is high, `ad_oe` is high, `ad_out` carries address bits 7..0, and `addr_hi` carries address bits 15..8. `addr_hi` holds that value until the cycle ends.
- R3: From T1 to the last T-state, `{io_m,s1,s0}` is 3'b011 for kind 0 (opcode fetch), 3'b010 for kind 1 (memory read), 3'b001 for kind 2 (memory write), 3'b110 for kind 3 (I/O read) and 3'b101 for kind 4 (I/O write). When idle the lines are 3'b000.
- R4: For kinds 0, 1 and 3, `rd_n` is low through T2 and T3 (four `clk` cycles) and high at all other times. `ad_oe` is low during those states.
- R5: For kinds 0, 1 and 3, `ad_in` is captured into `rdata` on the edge that ends T3. `rdata` holds that byte until the next reading cycle captures a new one. Reset clears `rdata` to zero.
- R6: For kinds 2 and 4, `ad_out` carries the write data with `ad_oe` high and `wr_n` low through T2 and T3. `wr_n` is high at all other times.
- R7: Kind 0 lasts four T-states, with a T4 in which no strobe is active. The other kinds last three T-states. The sequence fetch, read, read, write spends 13 T-states in cycles.
- R8: `done` goes high at the end of the final T-state and stays high for exactly one T-state, during which the block is idle.
- R9: A request is accepted only on a T-state boundary while the block is idle. Kinds 5 to 7 are ignored and start no cycle. A request that is held high through a cycle starts the next cycle only after one idle T-state.
- R10: After a synchronous reset, the block is idle with `done`=0, `ale`=0, `rd_n`=`wr_n`=1, `ad_oe`=0 and status 3'b000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Cycle request |
| req_kind | input | 3 | Cycle kind, 0..4 (see R3) |
| req_addr | input | 16 | Cycle address |
| req_wdata | input | 8 | Write byte |
| done | output | 1 | One-T-state completion pulse |
| rdata | output | 8 | Byte captured by the last reading cycle |
| state_clk | output | 1 | Divided state-rate phase |
| addr_hi | output | 8 | Address bits 15..8 |
| ad_out | output | 8 | Shared bus, output value |
| ad_in | input | 8 | Shared bus, input value |
| ad_oe | output | 1 | Shared bus output enable |
| ale | output | 1 | Address latch strobe |
| rd_n | output | 1 | Read strobe, active low |
| wr_n | output | 1 | Write strobe, active low |
| io_m | output | 1 | 1 for I/O, 0 for memory |
| s1 | output | 1 | Status bit 1 |
| s0 | output | 1 | Status bit 0 |

## Verification
The case that is hardest to reach from the ports is a request that stays asserted across a whole cycle and is still asserted at the boundary where `done` falls. That is the only point where the block may accept the request again. The stimulus holds `req_valid` through two back-to-back reads and measures the gap between the `ale` pulses. It also holds an illegal kind across several boundaries. The exact sampling edge of the read capture is tested by driving `ad_in` only while `rd_n` is low, so data that is captured one state early or late would not match.

// File: rtl/bcs_pkg.sv
package bcs_pkg;

    localparam int AW = 16;
    localparam int DW = 8;
    localparam int HW = AW - DW;

    typedef enum logic [2:0] {
        K_FETCH = 3'd0,
        K_MRD   = 3'd1,
        K_MWR   = 3'd2,
        K_IORD  = 3'd3,
        K_IOWR  = 3'd4
    } kind_e;

    typedef enum logic [2:0] {
        TS_IDLE = 3'd0,
        TS_1    = 3'd1,
        TS_2    = 3'd2,
        TS_3    = 3'd3,
        TS_4    = 3'd4
    } tstate_e;

    typedef struct packed {
        logic io_m;
        logic s1;
        logic s0;
    } status_t;

    typedef struct packed {
        kind_e          kind;
        logic [AW-1:0]  addr;
        logic [DW-1:0]  wdata;
    } req_t;

    function automatic logic kind_ok(input logic [2:0] k);
        return k <= 3'd4;
    endfunction

    function automatic logic reads(input kind_e k);
        return (k == K_FETCH) || (k == K_MRD) || (k == K_IORD);
    endfunction

    function automatic logic writes(input kind_e k);
        return (k == K_MWR) || (k == K_IOWR);
    endfunction

    function automatic tstate_e final_state(input kind_e k);
        return (k == K_FETCH) ? TS_4 : TS_3;
    endfunction

    function automatic status_t status_of(input kind_e k);
        status_t s;
        case (k)
            K_FETCH: s = '{io_m: 1'b0, s1: 1'b1, s0: 1'b1};
            K_MRD:   s = '{io_m: 1'b0, s1: 1'b1, s0: 1'b0};
            K_MWR:   s = '{io_m: 1'b0, s1: 1'b0, s0: 1'b1};
            K_IORD:  s = '{io_m: 1'b1, s1: 1'b1, s0: 1'b0};
            K_IOWR:  s = '{io_m: 1'b1, s1: 1'b0, s0: 1'b1};
            default: s = '{io_m: 1'b0, s1: 1'b0, s0: 1'b0};
        endcase
        return s;
    endfunction

endpackage

// File: rtl/bcs_clkdiv.sv
module bcs_clkdiv #(
    parameter int DIV_RATIO = 2
) (
    input  logic clk,
    input  logic rst,
    output logic tick,
    output logic phase
);
    localparam int CW   = (DIV_RATIO > 2) ? $clog2(DIV_RATIO) : 1;
    localparam int HALF = DIV_RATIO / 2;

    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt <= '0;
        end else if (cnt == CW'(DIV_RATIO - 1)) begin
            cnt <= '0;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end

    assign tick  = (cnt == CW'(DIV_RATIO - 1));
    assign phase = (cnt >= CW'(HALF));

    // one enable per divided period
    assert_tick_alt_R1: assert property (@(posedge clk) disable iff (rst)
        tick |=> !tick);

endmodule

// File: rtl/bcs_fsm.sv
module bcs_fsm
    import bcs_pkg::*;
(
    input  logic          clk,
    input  logic          rst,
    input  logic          tick,
    input  logic          req_valid,
    input  logic [2:0]    req_kind,
    input  logic [AW-1:0] req_addr,
    input  logic [DW-1:0] req_wdata,
    input  logic [DW-1:0] ad_in,
    output tstate_e       st,
    output req_t          cur,
    output logic          done,
    output logic [DW-1:0] rdata
);

    always_ff @(posedge clk) begin
        if (rst) begin
            st    <= TS_IDLE;
            cur   <= '0;
            done  <= 1'b0;
            rdata <= '0;
        end else if (tick) begin
            done <= 1'b0;
            case (st)
                TS_IDLE: begin
                    if (req_valid && kind_ok(req_kind)) begin
                        cur.kind  <= kind_e'(req_kind);
                        cur.addr  <= req_addr;
                        cur.wdata <= req_wdata;
                        st        <= TS_1;
                    end
                end
                TS_1: st <= TS_2;
                TS_2: st <= TS_3;
                TS_3: begin
                    if (reads(cur.kind)) begin
                        rdata <= ad_in;
                    end
                    if (final_state(cur.kind) == TS_3) begin
                        st   <= TS_IDLE;
                        done <= 1'b1;
                    end else begin
                        st <= TS_4;
                    end
                end
                TS_4: begin
                    st   <= TS_IDLE;
                    done <= 1'b1;
                end
                default: st <= TS_IDLE;
            endcase
        end
    end

    assert_state_hold_R1: assert property (@(posedge clk) disable iff (rst)
        !tick |=> $stable(st));

    assert_done_idle_R8: assert property (@(posedge clk) disable iff (rst)
        done |-> (st == TS_IDLE));

    assert_t4_fetch_only_R7: assert property (@(posedge clk) disable iff (rst)
        (st == TS_4) |-> (cur.kind == K_FETCH));

endmodule

// File: rtl/bcs_pindrv.sv
module bcs_pindrv
    import bcs_pkg::*;
(
    input  tstate_e       st,
    input  req_t          cur,
    output logic [HW-1:0] addr_hi,
    output logic [DW-1:0] ad_out,
    output logic          ad_oe,
    output logic          ale,
    output logic          rd_n,
    output logic          wr_n,
    output status_t       stat
);

    always_comb begin
        addr_hi = cur.addr[AW-1:DW];
        ad_out  = '0;
        ad_oe   = 1'b0;
        ale     = 1'b0;
        rd_n    = 1'b1;
        wr_n    = 1'b1;
        stat    = '0;
        if (st != TS_IDLE) begin
            stat = status_of(cur.kind);
        end
        case (st)
            TS_1: begin
                ale    = 1'b1;
                ad_oe  = 1'b1;
                ad_out = cur.addr[DW-1:0];
            end
            TS_2, TS_3: begin
                if (writes(cur.kind)) begin
                    ad_oe  = 1'b1;
                    ad_out = cur.wdata;
                    wr_n   = 1'b0;
                end else begin
                    rd_n = 1'b0;
                end
            end
            default: ;
        endcase
    end

endmodule

// File: rtl/bus_cycle_seq.sv
module bus_cycle_seq
    import bcs_pkg::*;
#(
    parameter int DIV_RATIO = 2
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          req_valid,
    input  logic [2:0]    req_kind,
    input  logic [AW-1:0] req_addr,
    input  logic [DW-1:0] req_wdata,
    output logic          done,
    output logic [DW-1:0] rdata,
    output logic          state_clk,
    output logic [HW-1:0] addr_hi,
    output logic [DW-1:0] ad_out,
    input  logic [DW-1:0] ad_in,
    output logic          ad_oe,
    output logic          ale,
    output logic          rd_n,
    output logic          wr_n,
    output logic          io_m,
    output logic          s1,
    output logic          s0
);

    logic    tick;
    tstate_e st;
    req_t    cur;
    status_t stat;

    bcs_clkdiv #(.DIV_RATIO(DIV_RATIO)) u_div (
        .clk   (clk),
        .rst   (rst),
        .tick  (tick),
        .phase (state_clk)
    );

    bcs_fsm u_fsm (
        .clk       (clk),
        .rst       (rst),
        .tick      (tick),
        .req_valid (req_valid),
        .req_kind  (req_kind),
        .req_addr  (req_addr),
        .req_wdata (req_wdata),
        .ad_in     (ad_in),
        .st        (st),
        .cur       (cur),
        .done      (done),
        .rdata     (rdata)
    );

    bcs_pindrv u_pins (
        .st      (st),
        .cur     (cur),
        .addr_hi (addr_hi),
        .ad_out  (ad_out),
        .ad_oe   (ad_oe),
        .ale     (ale),
        .rd_n    (rd_n),
        .wr_n    (wr_n),
        .stat    (stat)
    );

    assign io_m = stat.io_m;
    assign s1   = stat.s1;
    assign s0   = stat.s0;

    // address strobe spans one T-state (two clk cycles at the default ratio)
    assert_ale_one_state_R2: assert property (@(posedge clk) disable iff (rst)
        $rose(ale) |=> (ale ##1 !ale));

    assert_rd_two_states_R4: assert property (@(posedge clk) disable iff (rst)
        $fell(rd_n) |=> (!rd_n ##1 !rd_n ##1 !rd_n ##1 rd_n));

    assert_no_contention_R4: assert property (@(posedge clk) disable iff (rst)
        !rd_n |-> !ad_oe);

    assert_strobe_excl_R6: assert property (@(posedge clk) disable iff (rst)
        !(!rd_n && !wr_n));

    assert_done_after_cycle_R8: assert property (@(posedge clk) disable iff (rst)
        $rose(done) |-> $past(io_m || s1 || s0));

endmodule

// File: tb/bus_cycle_seq_bench.sv
`timescale 1ns/1ps
module bus_cycle_seq_bench;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_valid = 1'b0;
    logic [2:0]  req_kind = '0;
    logic [15:0] req_addr = '0;
    logic [7:0]  req_wdata = '0;
    logic        done;
    logic [7:0]  rdata;
    logic        state_clk;
    logic [7:0]  addr_hi;
    logic [7:0]  ad_out;
    logic [7:0]  ad_in;
    logic        ad_oe, ale, rd_n, wr_n, io_m, s1, s0;
    logic [7:0]  rbyte = 8'h00;

    int n_chk = 0;
    int n_fail = 0;

    always #2.5 clk = ~clk;

    // external device drives the shared bus only while read strobe is active
    assign ad_in = (!rd_n) ? rbyte : 8'h00;

    bus_cycle_seq u_bus_cycle_seq (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_kind(req_kind),
        .req_addr(req_addr), .req_wdata(req_wdata), .done(done), .rdata(rdata),
        .state_clk(state_clk), .addr_hi(addr_hi), .ad_out(ad_out), .ad_in(ad_in),
        .ad_oe(ad_oe), .ale(ale), .rd_n(rd_n), .wr_n(wr_n),
        .io_m(io_m), .s1(s1), .s0(s0)
    );

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    function automatic logic [2:0] stat_exp(input int k);
        case (k)
            0: return 3'b011;
            1: return 3'b010;
            2: return 3'b001;
            3: return 3'b110;
            4: return 3'b101;
            default: return 3'b000;
        endcase
    endfunction

    // ---------------- behavioural reference model ----------------
    bit         m_ph;
    int         m_pos, m_len, m_kind;
    bit         m_done;
    logic [15:0] m_addr;
    logic [7:0]  m_wd, m_rd;

    always @(posedge clk) begin
        if (rst) begin
            m_ph = 0; m_pos = 0; m_len = 0; m_kind = 0;
            m_done = 0; m_addr = 0; m_wd = 0; m_rd = 0;
        end else begin
            if (m_ph) begin
                m_done = 0;
                if (m_pos == 0) begin
                    if (req_valid && req_kind <= 3'd4) begin
                        m_kind = int'(req_kind);
                        m_addr = req_addr;
                        m_wd   = req_wdata;
                        m_len  = (m_kind == 0) ? 4 : 3;
                        m_pos  = 1;
                    end
                end else begin
                    if (m_pos == 3 && (m_kind == 0 || m_kind == 1 || m_kind == 3))
                        m_rd = ad_in;
                    if (m_pos == m_len) begin
                        m_pos = 0;
                        m_done = 1;
                    end else begin
                        m_pos++;
                    end
                end
            end
            m_ph = !m_ph;
        end
    end

    bit live = 0;
    int stat_clks = 0;
    bit count_stat = 0;

    always @(negedge clk) begin
        if (!rst && live) begin
            bit is_rd, is_wr, mid;
            logic [2:0] es;
            is_rd = (m_pos != 0) && (m_kind == 0 || m_kind == 1 || m_kind == 3);
            is_wr = (m_pos != 0) && (m_kind == 2 || m_kind == 4);
            mid   = (m_pos == 2 || m_pos == 3);
            es    = (m_pos != 0) ? stat_exp(m_kind) : 3'b000;
            chk(state_clk == m_ph, "R1 state_clk", state_clk, m_ph);
            chk(ale == (m_pos == 1), "R2 ale", ale, m_pos == 1);
            if (m_pos == 1) chk(ad_out == m_addr[7:0], "R2 ad_out addr", ad_out, m_addr[7:0]);
            if (m_pos != 0) chk(addr_hi == m_addr[15:8], "R2 addr_hi", addr_hi, m_addr[15:8]);
            chk({io_m, s1, s0} == es, "R3 status", {io_m, s1, s0}, es);
            chk(rd_n == !(is_rd && mid), "R4 rd_n", rd_n, !(is_rd && mid));
            chk(ad_oe == ((m_pos == 1) || (is_wr && mid)), "R4/R6 ad_oe", ad_oe,
                (m_pos == 1) || (is_wr && mid));
            chk(wr_n == !(is_wr && mid), "R6 wr_n", wr_n, !(is_wr && mid));
            if (is_wr && mid) chk(ad_out == m_wd, "R6 write data", ad_out, m_wd);
            chk(rdata == m_rd, "R5 rdata", rdata, m_rd);
            chk(done == m_done, "R8 done", done, m_done);
            if (m_pos == 4) chk(rd_n && wr_n && !ad_oe, "R7 T4 quiet", {rd_n, wr_n, ad_oe}, 3'b110);
        end
        if (count_stat && ({io_m, s1, s0} != 3'b000)) stat_clks++;
    end

    task automatic do_cycle(input int k, input logic [15:0] a, input logic [7:0] wd, input logic [7:0] rb);
        @(negedge clk);
        rbyte = rb; req_kind = k[2:0]; req_addr = a; req_wdata = wd; req_valid = 1'b1;
        while (!ale) @(negedge clk);
        req_valid = 1'b0;
        while (!done) @(negedge clk);
        while (done) @(negedge clk);
    endtask

    task automatic finish_run();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL R8 watchdog expired actual=0 expected=1");
        finish_run();
    end

    initial begin
        repeat (6) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R10: idle after reset
        chk(!done && !ale && rd_n && wr_n && !ad_oe, "R10 idle strobes",
            {done, ale, rd_n, wr_n, ad_oe}, 5'b00110);
        chk({io_m, s1, s0} == 3'b000, "R10 status", {io_m, s1, s0}, 0);
        chk(rdata == 8'h00, "R10 rdata", rdata, 0);
        live = 1;

        // R7: fetch + read + read + write spends 13 T-states
        count_stat = 1;
        do_cycle(0, 16'h2010, 8'h00, 8'h32);
        chk(rdata == 8'h32, "R5 fetch byte", rdata, 8'h32);
        do_cycle(1, 16'h2011, 8'h00, 8'h65);
        chk(rdata == 8'h65, "R5 read byte", rdata, 8'h65);
        do_cycle(1, 16'h2012, 8'h00, 8'h20);
        do_cycle(2, 16'h2065, 8'hA7, 8'h00);
        count_stat = 0;
        chk(stat_clks == 26, "R7 total T-states x2", stat_clks, 26);
        chk(rdata == 8'h20, "R5 write keeps rdata", rdata, 8'h20);

        // I/O cycles
        do_cycle(3, 16'h00F3, 8'h00, 8'h5C);
        chk(rdata == 8'h5C, "R5 io read byte", rdata, 8'h5C);
        do_cycle(4, 16'hBE42, 8'h3D, 8'h00);
        do_cycle(0, 16'hFFFF, 8'h00, 8'hC3);

        // R9: illegal kinds ignored
        begin
            int ale_seen = 0;
            @(negedge clk);
            req_kind = 3'd6; req_addr = 16'h1234; req_valid = 1'b1;
            for (int i = 0; i < 12; i++) begin
                @(negedge clk);
                if (ale || !rd_n || !wr_n) ale_seen++;
            end
            req_kind = 3'd7;
            for (int i = 0; i < 8; i++) begin
                @(negedge clk);
                if (ale || !rd_n || !wr_n) ale_seen++;
            end
            req_valid = 1'b0;
            chk(ale_seen == 0, "R9 illegal kind ignored", ale_seen, 0);
        end

        // R9: held request restarts only after one idle T-state
        begin
            int t_first = -1, gap = -1, dones = 0, t = 0;
            bit prev_ale = 0, prev_done = 0;
            @(negedge clk);
            rbyte = 8'h99; req_kind = 3'd1; req_addr = 16'h4455; req_valid = 1'b1;
            while (dones < 2) begin
                @(negedge clk);
                t++;
                if (ale && !prev_ale) begin
                    if (t_first < 0) t_first = t; else if (gap < 0) gap = t - t_first;
                end
                if (done && !prev_done) dones++;
                prev_ale = ale; prev_done = done;
            end
            req_valid = 1'b0;
            while (done) @(negedge clk);
            chk(gap == 8, "R9 held request gap", gap, 8);
            repeat (6) @(negedge clk);
            chk(!ale && rd_n, "R9 no third cycle", {ale, rd_n}, 2'b01);
        end

        // R10: reset mid-cycle returns to idle
        @(negedge clk);
        req_kind = 3'd2; req_addr = 16'h7000; req_wdata = 8'h11; req_valid = 1'b1;
        while (!ale) @(negedge clk);
        req_valid = 1'b0;
        @(negedge clk); @(negedge clk);
        rst = 1'b1;
        @(negedge clk); @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk(wr_n && !ad_oe && {io_m, s1, s0} == 3'b000 && !done, "R10 reset mid-cycle",
            {wr_n, ad_oe, io_m, s1, s0, done}, 6'b100000);
        do_cycle(1, 16'h0102, 8'h00, 8'hE1);
        chk(rdata == 8'hE1, "R5 read after reset", rdata, 8'hE1);

        repeat (4) @(negedge clk);
        finish_run();
    end

endmodule